// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the execute datapath of a small accumulator-style controller. Each cycle it takes a 14-bit instruction word, the 8-bit working register W, an 8-bit register-file operand f and an incoming carry. From these it forms an 8-bit result and decides where that result is written: W, the register-file location, or nowhere. A byte-format word carries a direction bit that picks W or f as the target. A literal-format word always writes W and takes its second operand from the low eight bits of the word.

The carry, digit-carry and zero flags are held in registers inside the block and change only on a clock edge on which `exec_en` is high. Each operation updates its own subset of the three flags and leaves the rest unchanged. A combinational zero indication and a skip request let an outside sequencer turn the two count-and-skip operations into a conditional skip. Instruction fetch, register-file storage and the program counter are outside this block. The sequencer normally feeds `flag_c` back into `c_in`.

Top module: `acc_alu`

## Requirements
- R1: When `exec_en` is 1 and the word is supported, exactly one of `wr_w`/`wr_f` is 1. For byte words (bits 13:12 = 00), instruction bit 7 = 1 selects f and 0 selects W. Literal words (bits 13:12 = 11) always select W. When `exec_en` is 0, both enables are 0.
- R2: Add. Byte opcode 0111 adds W to f. Literal bits 13:9 = 11111 add W to k (bits 7:0). The result is the sum mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R3: Subtract. Byte opcode 0010 computes f − W. Literal bits 13:9 = 11110 compute k − W. The result is taken mod 256. C = 1 when the minuend is ≥ W. DC = 1 when the minuend's low nibble is ≥ W's low nibble. Z is set when the result is zero.
- R4: These operations update Z only and leave C and DC unchanged. Byte opcodes: AND 0101, OR 0100, XOR 0110, complement-f 1001, f+1 1010, f−1 0011. Literal bits 13:8: OR 111000, AND 111001, XOR 111010.
- R5: Byte opcode 1101 shifts f left, with `c_in` entering bit 0. Byte opcode 1100 shifts f right, with `c_in` entering bit 7. C takes the bit shifted out. Z and DC are unchanged.
- R6: These operations change no flag. Byte opcode 1110 exchanges the nibbles of f. Byte opcode 0000 with bit 7 = 1 writes W to f. Literal bits 13:10 = 1100 load k into W.
- R7: Byte opcode 0001 produces a zero result and sets Z. Bit 7 = 1 clears f and bit 7 = 0 clears W.
- R8: Byte opcode 1011 yields f−1 and byte opcode 1111 yields f+1. Neither changes any flag. `skip_req` is 1 exactly when such a word's result is zero.
- R9: Flags reset to 0. They change only on a rising clock edge with `exec_en` = 1.
- R10: Some words are not supported: bits 13:12 = 01 or 10, byte opcode 1000, byte opcode 0000 with bit 7 = 0, and literal bits 13:8 = 111011. For these, no enable is raised, no flag changes, `skip_req` is 0 and the result is zero.
- R11: `zero_res` is 1 exactly when `result` is zero, for every word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Execute clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec_en | input | 1 | Commit strobe: enables writes and flag update this cycle |
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Register-file operand |
| c_in | input | 1 | Carry entering the rotates |
| result | output | 8 | Computed result |
| wr_w | output | 1 | Write result to W |
| wr_f | output | 1 | Write result to the register file |
| zero_res | output | 1 | Result is zero |
| skip_req | output | 1 | Count-and-skip result reached zero |
| flag_c | output | 1 | Registered carry / not-borrow |
| flag_dc | output | 1 | Registered digit carry |
| flag_z | output | 1 | Registered zero |

## Verification
Some properties are checked on every cycle. The two write enables are never 1 together, and neither is raised while the block is idle or for a literal word writing f. A skip is only raised with a zero result, and the flags hold whenever `exec_en` is low. Spot properties also check the literal add and subtract carries, Z after a literal AND, and that a nibble swap leaves the flags alone.

The bench's scenarios are needed for the rest. These cover every result value, the digit-carry boundary at the nibble edge, rotation through `c_in`, masking of the flags per operation across long mixed sequences, and the quietness of unsupported words.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [4:0] {
      OP_NONE,
      OP_MOVW,
      OP_CLR,
      OP_SUB,
      OP_DEC,
      OP_IOR,
      OP_AND,
      OP_XOR,
      OP_ADD,
      OP_COM,
      OP_INC,
      OP_DECSZ,
      OP_RR,
      OP_RL,
      OP_SWAP,
      OP_INCSZ,
      OP_MOVL
   } op_e;

   typedef struct packed {
      op_e  op;
      logic src_lit;   // second operand is the literal, not f
      logic dst_f;     // result goes to register file
      logic upd_c;
      logic upd_dc;
      logic upd_z;
      logic skip_chk;  // raise skip when result is zero
   } dec_t;

   localparam logic [1:0] FMT_BYTE = 2'b00;
   localparam logic [1:0] FMT_LIT  = 2'b11;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
#(
   parameter int HI_W = 7
) (
   input  logic [HI_W-1:0] instr_hi,   // instruction bits from format down to direction bit
   output dec_t            dec
);

   localparam int FMT_MSB = HI_W - 1;
   localparam int OP_MSB  = HI_W - 3;

   logic [1:0] fmt;
   logic [3:0] opc;
   logic       dbit;

   assign fmt  = instr_hi[FMT_MSB -: 2];
   assign opc  = instr_hi[OP_MSB -: 4];
   assign dbit = instr_hi[0];

   always_comb begin
      dec = '{op: OP_NONE, src_lit: 1'b0, dst_f: 1'b0,
             upd_c: 1'b0, upd_dc: 1'b0, upd_z: 1'b0, skip_chk: 1'b0};
      if (fmt == FMT_BYTE) begin
         dec.dst_f = dbit;
         unique case (opc)
            4'b0000: dec.op = dbit ? OP_MOVW : OP_NONE;
            4'b0001: begin dec.op = OP_CLR;   dec.upd_z = 1'b1; end
            4'b0010: begin dec.op = OP_SUB;   dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
            4'b0011: begin dec.op = OP_DEC;   dec.upd_z = 1'b1; end
            4'b0100: begin dec.op = OP_IOR;   dec.upd_z = 1'b1; end
            4'b0101: begin dec.op = OP_AND;   dec.upd_z = 1'b1; end
            4'b0110: begin dec.op = OP_XOR;   dec.upd_z = 1'b1; end
            4'b0111: begin dec.op = OP_ADD;   dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
            4'b1000: dec.op = OP_NONE;
            4'b1001: begin dec.op = OP_COM;   dec.upd_z = 1'b1; end
            4'b1010: begin dec.op = OP_INC;   dec.upd_z = 1'b1; end
            4'b1011: begin dec.op = OP_DECSZ; dec.skip_chk = 1'b1; end
            4'b1100: begin dec.op = OP_RR;    dec.upd_c = 1'b1; end
            4'b1101: begin dec.op = OP_RL;    dec.upd_c = 1'b1; end
            4'b1110: dec.op = OP_SWAP;
            default: begin dec.op = OP_INCSZ; dec.skip_chk = 1'b1; end
         endcase
         if (dec.op == OP_NONE) dec.dst_f = 1'b0;
      end else if (fmt == FMT_LIT) begin
         dec.src_lit = 1'b1;
         casez (opc)
            4'b00??: dec.op = OP_MOVL;
            4'b1000: begin dec.op = OP_IOR; dec.upd_z = 1'b1; end
            4'b1001: begin dec.op = OP_AND; dec.upd_z = 1'b1; end
            4'b1010: begin dec.op = OP_XOR; dec.upd_z = 1'b1; end
            4'b110?: begin dec.op = OP_SUB; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
            4'b111?: begin dec.op = OP_ADD; dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
            default: dec.op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W       = 8,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              hcout   // carry out of the low half
);

   localparam int HALF = DATA_W / 2;

   generate
      if (SPLIT_NIBBLE) begin : g_split
         logic [HALF:0] lo_s;
         logic [HALF:0] hi_s;
         assign lo_s  = {1'b0, op_a[HALF-1:0]} + {1'b0, op_b[HALF-1:0]}
                      + {{HALF{1'b0}}, cin};
         assign hi_s  = {1'b0, op_a[DATA_W-1:HALF]} + {1'b0, op_b[DATA_W-1:HALF]}
                      + {{HALF{1'b0}}, lo_s[HALF]};
         assign sum   = {hi_s[HALF-1:0], lo_s[HALF-1:0]};
         assign cout  = hi_s[HALF];
         assign hcout = lo_s[HALF];
      end else begin : g_flat
         logic [DATA_W:0] full_s;
         logic [HALF:0]   lo_s;
         assign full_s = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};
         assign lo_s   = {1'b0, op_a[HALF-1:0]} + {1'b0, op_b[HALF-1:0]}
                       + {{HALF{1'b0}}, cin};
         assign sum    = full_s[DATA_W-1:0];
         assign cout   = full_s[DATA_W];
         assign hcout  = lo_s[HALF];
      end
   endgenerate

endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  op_e               op,
   input  logic              src_lit,
   input  logic [DATA_W-1:0] lit,
   input  logic [DATA_W-1:0] w_val,
   input  logic [DATA_W-1:0] f_val,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_new,
   output logic              dc_new
);

   localparam int HALF = DATA_W / 2;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] as_a;
   logic [DATA_W-1:0] as_b;
   logic              as_cin;
   logic [DATA_W-1:0] as_sum;
   logic              as_co;
   logic              as_hco;

   assign opnd = src_lit ? lit : f_val;

   // subtract as minuend + ~W + 1: carry out is then "no borrow"
   always_comb begin
      as_a   = w_val;
      as_b   = opnd;
      as_cin = 1'b0;
      if (op == OP_SUB) begin
         as_a   = opnd;
         as_b   = ~w_val;
         as_cin = 1'b1;
      end
   end

   alu_addsub #(
      .DATA_W       (DATA_W),
      .SPLIT_NIBBLE (SPLIT_NIBBLE)
   ) u_addsub (
      .op_a  (as_a),
      .op_b  (as_b),
      .cin   (as_cin),
      .sum   (as_sum),
      .cout  (as_co),
      .hcout (as_hco)
   );

   always_comb begin
      res    = '0;
      c_new  = as_co;
      dc_new = as_hco;
      unique case (op)
         OP_ADD,
         OP_SUB:   res = as_sum;
         OP_AND:   res = w_val & opnd;
         OP_IOR:   res = w_val | opnd;
         OP_XOR:   res = w_val ^ opnd;
         OP_COM:   res = ~f_val;
         OP_INC,
         OP_INCSZ: res = f_val + ONE;
         OP_DEC,
         OP_DECSZ: res = f_val - ONE;
         OP_RR: begin
            res   = {c_in, f_val[DATA_W-1:1]};
            c_new = f_val[0];
         end
         OP_RL: begin
            res   = {f_val[DATA_W-2:0], c_in};
            c_new = f_val[DATA_W-1];
         end
         OP_SWAP:  res = {f_val[HALF-1:0], f_val[DATA_W-1:HALF]};
         OP_MOVW:  res = w_val;
         OP_MOVL:  res = lit;
         OP_CLR:   res = '0;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/alu_status.sv
module alu_status (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic upd_c,
   input  logic upd_dc,
   input  logic upd_z,
   input  logic c_nxt,
   input  logic dc_nxt,
   input  logic z_nxt,
   output logic c_q,
   output logic dc_q,
   output logic z_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q  <= 1'b0;
         dc_q <= 1'b0;
         z_q  <= 1'b0;
      end else if (commit) begin
         if (upd_c)  c_q  <= c_nxt;
         if (upd_dc) dc_q <= dc_nxt;
         if (upd_z)  z_q  <= z_nxt;
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int INSTR_W      = 14,
   parameter bit SPLIT_NIBBLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec_en,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  w_in,
   input  logic [DATA_W-1:0]  f_in,
   input  logic               c_in,
   output logic [DATA_W-1:0]  result,
   output logic               wr_w,
   output logic               wr_f,
   output logic               zero_res,
   output logic               skip_req,
   output logic               flag_c,
   output logic               flag_dc,
   output logic               flag_z
);

   // decode window: format, opcode and direction bit sit just above the literal's low bits
   localparam int HI_W = INSTR_W - DATA_W + 1;

   generate
      if (INSTR_W != DATA_W + 6) begin : g_bad_instr_w
         $error("acc_alu: INSTR_W must equal DATA_W + 6");
      end
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data_w
         $error("acc_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] res_w;
   logic              c_nx;
   logic              dc_nx;
   logic              legal;

   alu_decode #(
      .HI_W (HI_W)
   ) u_dec (
      .instr_hi (instr[INSTR_W-1:DATA_W-1]),
      .dec      (dec)
   );

   alu_exec #(
      .DATA_W       (DATA_W),
      .SPLIT_NIBBLE (SPLIT_NIBBLE)
   ) u_exec (
      .op      (dec.op),
      .src_lit (dec.src_lit),
      .lit     (instr[DATA_W-1:0]),
      .w_val   (w_in),
      .f_val   (f_in),
      .c_in    (c_in),
      .res     (res_w),
      .c_new   (c_nx),
      .dc_new  (dc_nx)
   );

   assign legal    = (dec.op != OP_NONE);
   assign result   = res_w;
   assign zero_res = ~|res_w;
   assign skip_req = dec.skip_chk & zero_res;
   assign wr_w     = exec_en & legal & ~dec.dst_f;
   assign wr_f     = exec_en & legal &  dec.dst_f;

   alu_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (exec_en),
      .upd_c  (dec.upd_c),
      .upd_dc (dec.upd_dc),
      .upd_z  (dec.upd_z),
      .c_nxt  (c_nx),
      .dc_nxt (dc_nx),
      .z_nxt  (zero_res),
      .c_q    (flag_c),
      .dc_q   (flag_dc),
      .z_q    (flag_z)
   );

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
   parameter int DATA_W  = 8,
   parameter int INSTR_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               exec_en,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0]  w_in,
   input logic               wr_w,
   input logic               wr_f,
   input logic               zero_res,
   input logic               skip_req,
   input logic               flag_c,
   input logic               flag_dc,
   input logic               flag_z
);

   logic [1:0]      fmt;
   logic [5:0]      top6;
   logic [DATA_W:0] lit_sum;
   logic            lit_ge;

   assign fmt     = instr[INSTR_W-1 -: 2];
   assign top6    = instr[INSTR_W-1 -: 6];
   assign lit_sum = {1'b0, w_in} + {1'b0, instr[DATA_W-1:0]};
   assign lit_ge  = instr[DATA_W-1:0] >= w_in;

   AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_w && wr_f)); // R1
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |-> (!wr_w && !wr_f)); // R1
   AST_LIT_NEVER_F: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == 2'b11) |-> !wr_f); // R1
   AST_ADD_LIT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && top6[5:1] == 5'b11111) |=> (flag_c == $past(lit_sum[DATA_W]))); // R2
   AST_SUB_LIT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && top6[5:1] == 5'b11110) |=> (flag_c == $past(lit_ge))); // R3
   AST_AND_LIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && top6 == 6'b111001) |=> (flag_z == $past(zero_res))); // R4
   AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && top6 == 6'b001110) |=> $stable({flag_c, flag_dc, flag_z})); // R6
   AST_SKIP_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      skip_req |-> zero_res); // R8
   AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable({flag_c, flag_dc, flag_z})); // R9
   AST_UNSUPPORTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == 2'b01 || fmt == 2'b10) |-> (!wr_w && !wr_f && !skip_req)); // R10

endmodule

bind acc_alu alu_chk #(
   .DATA_W  (DATA_W),
   .INSTR_W (INSTR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .exec_en  (exec_en),
   .instr    (instr),
   .w_in     (w_in),
   .wr_w     (wr_w),
   .wr_f     (wr_f),
   .zero_res (zero_res),
   .skip_req (skip_req),
   .flag_c   (flag_c),
   .flag_dc  (flag_dc),
   .flag_z   (flag_z)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [13:0] instr = '0;
   logic [7:0]  w_in = '0;
   logic [7:0]  f_in = '0;
   logic        c_in = 1'b0;
   logic [7:0]  result;
   logic        wr_w, wr_f, zero_res, skip_req;
   logic        flag_c, flag_dc, flag_z;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // model flag state
   logic mc = 1'b0, mdc = 1'b0, mz = 1'b0;

   always #2.5 clk = ~clk;

   acc_alu u0 (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
      .w_in(w_in), .f_in(f_in), .c_in(c_in), .result(result),
      .wr_w(wr_w), .wr_f(wr_f), .zero_res(zero_res), .skip_req(skip_req),
      .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
   );

   task automatic model(input logic [13:0] i, input logic [7:0] w, input logic [7:0] f,
                        input logic ci,
                        output logic [7:0] res, output logic ok, output logic tof,
                        output logic skp, output logic uc, output logic udc, output logic uz,
                        output logic nc, output logic ndc, output string req);
      logic [8:0] s;
      logic [7:0] k;
      k = i[7:0];
      res = 8'h00; ok = 1'b0; tof = 1'b0; skp = 1'b0;
      uc = 1'b0; udc = 1'b0; uz = 1'b0; nc = 1'b0; ndc = 1'b0; req = "R10";
      if (i[13:12] == 2'b00) begin
         tof = i[7];
         ok  = 1'b1;
         case (i[11:8])
            4'h0: begin if (i[7]) begin res = w; req = "R6"; end else ok = 1'b0; end
            4'h1: begin res = 8'h00; uz = 1'b1; req = "R7"; end
            4'h2: begin s = {1'b0,f} - {1'b0,w}; res = s[7:0]; nc = (f >= w);
                        ndc = (f[3:0] >= w[3:0]); uc = 1; udc = 1; uz = 1; req = "R3"; end
            4'h3: begin res = f - 8'd1; uz = 1; req = "R4"; end
            4'h4: begin res = w | f; uz = 1; req = "R4"; end
            4'h5: begin res = w & f; uz = 1; req = "R4"; end
            4'h6: begin res = w ^ f; uz = 1; req = "R4"; end
            4'h7: begin s = {1'b0,w} + {1'b0,f}; res = s[7:0]; nc = s[8];
                        ndc = ({1'b0,w[3:0]} + {1'b0,f[3:0]}) > 5'd15; uc = 1; udc = 1; uz = 1; req = "R2"; end
            4'h8: ok = 1'b0;
            4'h9: begin res = ~f; uz = 1; req = "R4"; end
            4'hA: begin res = f + 8'd1; uz = 1; req = "R4"; end
            4'hB: begin res = f - 8'd1; skp = (res == 0); req = "R8"; end
            4'hC: begin res = {ci, f[7:1]}; nc = f[0]; uc = 1; req = "R5"; end
            4'hD: begin res = {f[6:0], ci}; nc = f[7]; uc = 1; req = "R5"; end
            4'hE: begin res = {f[3:0], f[7:4]}; req = "R6"; end
            default: begin res = f + 8'd1; skp = (res == 0); req = "R8"; end
         endcase
         if (!ok) begin tof = 1'b0; res = 8'h00; req = "R10"; end
      end else if (i[13:12] == 2'b11) begin
         ok = 1'b1;
         if (i[11:10] == 2'b00) begin res = k; req = "R6"; end
         else if (i[11:8] == 4'h8) begin res = w | k; uz = 1; req = "R4"; end
         else if (i[11:8] == 4'h9) begin res = w & k; uz = 1; req = "R4"; end
         else if (i[11:8] == 4'hA) begin res = w ^ k; uz = 1; req = "R4"; end
         else if (i[11:9] == 3'b110) begin s = {1'b0,k} - {1'b0,w}; res = s[7:0]; nc = (k >= w);
            ndc = (k[3:0] >= w[3:0]); uc = 1; udc = 1; uz = 1; req = "R3"; end
         else if (i[11:9] == 3'b111) begin s = {1'b0,w} + {1'b0,k}; res = s[7:0]; nc = s[8];
            ndc = ({1'b0,w[3:0]} + {1'b0,k[3:0]}) > 5'd15; uc = 1; udc = 1; uz = 1; req = "R2"; end
         else ok = 1'b0;
      end
   endtask

   // drive at negedge, check combinational outputs, clock, check flags
   task automatic apply(input logic en, input logic [13:0] i, input logic [7:0] w,
                        input logic [7:0] f, input logic ci);
      logic [7:0] er; logic ok, tof, skp, uc, udc, uz, nc, ndc;
      logic ew, ef;
      string req;
      @(negedge clk);
      exec_en = en; instr = i; w_in = w; f_in = f; c_in = ci;
      model(i, w, f, ci, er, ok, tof, skp, uc, udc, uz, nc, ndc, req);
      ew = en & ok & ~tof;
      ef = en & ok & tof;
      #1;
      n_tests++;
      if (result !== er || wr_w !== ew || wr_f !== ef || skip_req !== skp || zero_res !== (er == 0)) begin
         n_fail++;
         $display("FAIL %s/R1/R11 instr=%h: got res=%h ww=%b wf=%b skip=%b zero=%b exp res=%h ww=%b wf=%b skip=%b zero=%b",
                  req, i, result, wr_w, wr_f, skip_req, zero_res, er, ew, ef, skp, (er == 0));
      end
      @(posedge clk);
      if (en) begin
         if (uc)  mc  = nc;
         if (udc) mdc = ndc;
         if (uz)  mz  = (er == 0);
      end
      @(negedge clk);
      n_tests++;
      if ({flag_c, flag_dc, flag_z} !== {mc, mdc, mz}) begin
         n_fail++;
         $display("FAIL %s/R9 flags instr=%h en=%b: got c,dc,z=%b%b%b exp %b%b%b",
                  req, i, en, flag_c, flag_dc, flag_z, mc, mdc, mz);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'h1F2E3D4C);
      repeat (3) @(posedge clk);
      #1;
      n_tests++;  // R9 reset state
      if ({flag_c, flag_dc, flag_z} !== 3'b000) begin
         n_fail++;
         $display("FAIL R9 reset flags got %b%b%b exp 000", flag_c, flag_dc, flag_z);
      end
      @(negedge clk) rst_n = 1'b1;

      // R2: digit carry edge, full carry with zero
      apply(1, 14'h3E0F, 8'h01, 8'h00, 0);
      apply(1, 14'h3E01, 8'hFF, 8'h00, 0);
      apply(1, 14'h0780, 8'h80, 8'h80, 0);
      // R3: equal operands, borrow, nibble borrow
      apply(1, 14'h3C55, 8'h55, 8'h00, 0);
      apply(1, 14'h0280, 8'h10, 8'h0F, 0);
      apply(1, 14'h0200, 8'h01, 8'h10, 0);
      // R4 Z only: AND to zero, COMF of FF
      apply(1, 14'h3900, 8'hAA, 8'h00, 0);
      apply(1, 14'h0980, 8'h00, 8'hFF, 0);
      // R5 rotates through c_in
      apply(1, 14'h0D80, 8'h00, 8'h81, 1);
      apply(1, 14'h0C00, 8'h00, 8'h02, 1);
      // R6 swap, move W to f, move literal
      apply(1, 14'h0E80, 8'h00, 8'hA5, 0);
      apply(1, 14'h0085, 8'h3C, 8'h00, 0);
      apply(1, 14'h3000, 8'h3C, 8'h00, 0);
      // R7 clears
      apply(1, 14'h0180, 8'h12, 8'h34, 0);
      apply(1, 14'h0100, 8'h12, 8'h34, 0);
      // R8 skip boundaries
      apply(1, 14'h0F80, 8'h00, 8'hFF, 0);
      apply(1, 14'h0B00, 8'h00, 8'h01, 0);
      apply(1, 14'h0B00, 8'h00, 8'h02, 0);
      // R10 unsupported words
      apply(1, 14'h1234, 8'h00, 8'h00, 0);
      apply(1, 14'h0880, 8'h00, 8'h00, 0);
      apply(1, 14'h0000, 8'h00, 8'h00, 0);
      apply(1, 14'h3B00, 8'h00, 8'h00, 0);
      // R9 no commit: flags hold, no writes
      apply(0, 14'h3E01, 8'hFF, 8'h00, 0);

      for (int n = 0; n < 4000; n++) begin
         logic [13:0] ri;
         logic [1:0]  sel;
         ri  = 14'($urandom);
         sel = 2'($urandom % 8 == 0 ? ($urandom % 2 ? 2'b01 : 2'b10)
                                    : ($urandom % 2 ? 2'b00 : 2'b11));
         ri[13:12] = sel;
         apply(($urandom % 10) != 0, ri, 8'($urandom), 8'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule